// File: doc/BRIEF.md
# Pipelined Barrett Modular Multiplier

This block multiplies two 64-bit residues and reduces the product modulo the fixed prime q = 18434813901432784897, which lies just below 2^64. It uses Barrett reduction. The constant mu = floor(2^128 / q) is 65 bits wide. It is split into an implicit leading one, which becomes a 64-bit shift of the product, and a 64-bit low part. The low part drives two constant multipliers that work on the upper and lower halves of the product.

The datapath is fully pipelined and never stalls. A new operand pair may be offered on every clock with `inValid` high. Each accepted pair returns one fully reduced result, flagged by `outValid`, a fixed 14 cycles later. Those 14 cycles are made up as follows:

- 6 stages for the full product
- 3 stages for the mu multiplies
- 1 stage that forms the quotient estimate
- 3 stages for the multiply by q
- 1 stage for the final conditional subtraction

Results leave in issue order. The unit is intended as the single modular multiplier inside a transform engine, which keeps it busy with one butterfly multiply per cycle.

Top module: `barrettModMul`

## Requirements
- R1: While `rstN` is low, and until the first accepted pair comes out, `outValid` is 0 and `result` is 0.
- R2: For operands `opA` and `opB` both below q = 18434813901432784897, the returned `result` equals (opA * opB) mod q computed exactly.
- R3: A pair sampled with `inValid` high at rising edge k produces `outValid` high and its `result` right after rising edge k+13, which is 14 register stages counting the sampling edge.
- R4: Pairs presented on consecutive cycles are all accepted without stalls. They return on consecutive cycles in the order issued, one result per cycle.
- R5: A cycle with `inValid` low ignores `opA` and `opB` and yields no `outValid` 14 cycles later. While `outValid` is low, `result` keeps its previous value.
- R6: Every result flagged by `outValid` is strictly below q, including products of operands close to q. A single conditional subtraction of q is enough, because the remainder before it is below 2q.
- R7: Corner operands reduce correctly. A zero operand gives 0, an operand equal to 1 returns the other operand, and (q-1)*(q-1) gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on `opA`/`opB` is to be accepted this cycle |
| opA | input | 64 | First residue, below q |
| opB | input | 64 | Second residue, below q |
| outValid | output | 1 | `result` carries a new reduced product |
| result | output | 64 | (opA * opB) mod q of the pair issued 14 cycles earlier |

## Verification
Two kinds of event can fall in the same cycle. In one, a result emerges at the tail while a new pair is being accepted at the head. In the other, the final stage is skipped for a bubble while upstream stages still carry live data. Both are provoked by a long back-to-back burst and by an irregular valid pattern that feeds garbage operands during bubbles. Each emerging result is matched against an exactly computed 128-bit reference. Its arrival cycle is compared with its issue cycle to confirm the fixed latency. On every idle cycle the output is also compared with the last valid result.

// File: rtl/barrettPkg.sv
`timescale 1ns/1ps
package barrettPkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned PROD_W = 2 * WORD_W;
  localparam int unsigned REM_W  = WORD_W + 1;
  localparam int unsigned EST_W  = PROD_W + 2;

  localparam logic [WORD_W-1:0] MODULUS = 64'd18434813901432784897;
  // mu = floor(2^128 / q); top bit (weight 2^64) is implicit, low part kept
  localparam logic [PROD_W:0] MU_FULL =
    {1'b1, {PROD_W{1'b0}}} / {{(WORD_W+1){1'b0}}, MODULUS};
  localparam logic [WORD_W-1:0] MU_LO = MU_FULL[WORD_W-1:0];

  typedef struct packed {
    logic combineEn;  // quotient-estimate register captures
    logic finalEn;    // reduced result register captures
  } strobes_t;
endpackage

// File: rtl/mulPipe.sv
`timescale 1ns/1ps
module mulPipe #(
  parameter int unsigned AW     = 64,
  parameter int unsigned BW     = 64,
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic [AW-1:0]     opA,
  input  logic [BW-1:0]     opB,
  output logic [AW+BW-1:0]  prod
);
  localparam int unsigned PW = AW + BW;

  logic [PW-1:0] rawProd;
  logic [PW-1:0] stageQ [STAGES];

  // Product formed once, then carried through STAGES registers for retiming
  assign rawProd = {{BW{1'b0}}, opA} * {{AW{1'b0}}, opB};

  always_ff @(posedge clk) begin
    stageQ[0] <= rawProd;
    for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
  end

  assign prod = stageQ[STAGES-1];
endmodule

// File: rtl/delayLine.sv
`timescale 1ns/1ps
module delayLine #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] tap [N];

  always_ff @(posedge clk) begin
    tap[0] <= din;
    for (int i = 1; i < N; i++) tap[i] <= tap[i-1];
  end

  assign dout = tap[N-1];
endmodule

// File: rtl/barrettCtrl.sv
`timescale 1ns/1ps
module barrettCtrl
  import barrettPkg::*;
#(
  parameter int unsigned PROD_STAGES = 6,
  parameter int unsigned MU_STAGES   = 3,
  parameter int unsigned Q_STAGES    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output strobes_t strobes,
  output logic     outValid
);
  localparam int unsigned LAT       = PROD_STAGES + MU_STAGES + 1 + Q_STAGES + 1;
  localparam int unsigned COMBINE_I = PROD_STAGES + MU_STAGES - 1;
  localparam int unsigned FINAL_I   = LAT - 2;

  // vldPipe[i] marks live data held in datapath register stage i+1
  logic [LAT-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[LAT-2:0], inValid};
  end

  assign strobes.combineEn = vldPipe[COMBINE_I];
  assign strobes.finalEn   = vldPipe[FINAL_I];
  assign outValid          = vldPipe[LAT-1];
endmodule

// File: rtl/barrettDatapath.sv
`timescale 1ns/1ps
module barrettDatapath
  import barrettPkg::*;
#(
  parameter int unsigned PROD_STAGES = 6,
  parameter int unsigned MU_STAGES   = 3,
  parameter int unsigned Q_STAGES    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result
);
  logic [PROD_W-1:0] fullProd;
  logic [PROD_W-1:0] xAligned;
  logic [PROD_W-1:0] muHiProd;
  logic [PROD_W-1:0] muLoProd;
  logic [EST_W-1:0]  estSum;
  logic [WORD_W-1:0] qEstQ;
  logic [REM_W-1:0]  xLowQ;
  logic [PROD_W-1:0] qProd;
  logic [REM_W-1:0]  xLowAligned;
  logic [REM_W-1:0]  remainder;
  logic [REM_W-1:0]  reduced;
  logic              unusedBits;

  // Full operand product
  mulPipe #(.AW(WORD_W), .BW(WORD_W), .STAGES(PROD_STAGES)) u_prodMul (
    .clk(clk), .opA(opA), .opB(opB), .prod(fullProd));

  // x * mu / 2^128 = (x + xHi*muLo + floor(xLo*muLo / 2^64)) / 2^64
  mulPipe #(.AW(WORD_W), .BW(WORD_W), .STAGES(MU_STAGES)) u_muHiMul (
    .clk(clk), .opA(fullProd[PROD_W-1:WORD_W]), .opB(MU_LO), .prod(muHiProd));
  mulPipe #(.AW(WORD_W), .BW(WORD_W), .STAGES(MU_STAGES)) u_muLoMul (
    .clk(clk), .opA(fullProd[WORD_W-1:0]), .opB(MU_LO), .prod(muLoProd));
  delayLine #(.W(PROD_W), .N(MU_STAGES)) u_xAlign (
    .clk(clk), .din(fullProd), .dout(xAligned));

  // Implicit 2^64 term of mu compensated by adding x itself
  assign estSum = {2'b00, xAligned} + {2'b00, muHiProd}
                + {{(EST_W-WORD_W){1'b0}}, muLoProd[PROD_W-1:WORD_W]};

  always_ff @(posedge clk) begin
    if (strobes.combineEn) begin
      qEstQ <= estSum[PROD_W-1:WORD_W];
      xLowQ <= xAligned[REM_W-1:0];
    end
  end

  // Quotient estimate times modulus; only the low 65 bits matter
  mulPipe #(.AW(WORD_W), .BW(WORD_W), .STAGES(Q_STAGES)) u_qMul (
    .clk(clk), .opA(qEstQ), .opB(MODULUS), .prod(qProd));
  delayLine #(.W(REM_W), .N(Q_STAGES)) u_xLowAlign (
    .clk(clk), .din(xLowQ), .dout(xLowAligned));

  assign remainder = xLowAligned - qProd[REM_W-1:0];
  assign reduced   = remainder - {1'b0, MODULUS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (strobes.finalEn) result <= (remainder >= {1'b0, MODULUS}) ?
                                        reduced[WORD_W-1:0] : remainder[WORD_W-1:0];
  end

  assign unusedBits = ^{estSum[EST_W-1:PROD_W], estSum[WORD_W-1:0],
                        muLoProd[WORD_W-1:0], qProd[PROD_W-1:REM_W], reduced[REM_W-1]};

  // R2: quotient estimate never exceeds the 128-bit sum range it is cut from
  p_quotient_fits_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.combineEn |-> (estSum[EST_W-1:PROD_W] == 2'b00));

  // R6: remainder entering the last stage needs at most one subtraction
  p_single_sub_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finalEn |-> ({1'b0, remainder} < {1'b0, MODULUS, 1'b0}));
endmodule

// File: rtl/barrettModMul.sv
`timescale 1ns/1ps
module barrettModMul
  import barrettPkg::*;
#(
  parameter int unsigned PROD_STAGES = 6,
  parameter int unsigned MU_STAGES   = 3,
  parameter int unsigned Q_STAGES    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  strobes_t strobes;

  barrettCtrl #(.PROD_STAGES(PROD_STAGES), .MU_STAGES(MU_STAGES), .Q_STAGES(Q_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes), .outValid(outValid));

  barrettDatapath #(.PROD_STAGES(PROD_STAGES), .MU_STAGES(MU_STAGES), .Q_STAGES(Q_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB), .result(result));

  // R6: every flagged result is fully reduced
  p_reduced_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result < MODULUS));

  // R5: output register holds whenever no result is flagged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));
endmodule

// File: tb/test_barrettModMul.sv
`timescale 1ns/1ps
module test_barrettModMul;
  localparam logic [63:0] Q   = 64'd18434813901432784897;
  localparam int          LAT = 14;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] opA, opB;
  logic        outValid;
  logic [63:0] result;

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [63:0] expVal[$];
  int          expCyc[$];
  logic [63:0] lastResult = '0;
  logic [63:0] headVal;
  int          headCyc;
  string       curReq = "R2";

  always #4 clk = ~clk;

  barrettModMul i_barrettModMul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result));

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] refMul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b};
    return 64'(p % {64'd0, Q});
  endfunction

  function automatic logic [63:0] randRes();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (v >= Q) v = v - Q;
    return v;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Output monitor: value, latency, hold behaviour
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expVal.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: outValid with result %h, expected no output", result);
        end else begin
          headVal = expVal.pop_front();
          headCyc = expCyc.pop_front();
          checks++;
          if (result !== headVal) begin
            errors++;
            $display("FAIL %s: result %h expected %h", curReq, result, headVal);
          end
          checks++;
          if (result >= Q) begin
            errors++;
            $display("FAIL R6: result %h expected below %h", result, Q);
          end
          checks++;
          if (cyc - headCyc != LAT) begin
            errors++;
            $display("FAIL R3: latency %0d expected %0d", cyc - headCyc, LAT);
          end
        end
        lastResult = result;
      end else begin
        checks++;
        if (result !== lastResult) begin
          errors++;
          $display("FAIL R5: idle result %h expected held %h", result, lastResult);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R4: watchdog at cycle %0d expected end before %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic sendOp(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    expVal.push_back(refMul(a, b));
    expCyc.push_back(cyc);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    opA = randRes(); opB = randRes(); inValid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < LAT + 3; i++) idleCycle();
    checks++;
    if (expVal.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d results missing, expected 0", req, expVal.size());
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || result !== 64'd0) begin
        errors++;
        $display("FAIL R1: outValid %b result %h expected 0 and 0", outValid, result);
      end
    end
    rstN = 1'b1;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || result !== 64'd0) begin
        errors++;
        $display("FAIL R1: outValid %b result %h expected 0 and 0", outValid, result);
      end
    end
  endtask

  task automatic testSingle();
    curReq = "R3";
    sendOp(64'd123456789, 64'd987654321);
    drain("R3");
  endtask

  task automatic testCorners();
    curReq = "R7";
    sendOp(64'd0, 64'd0);
    sendOp(64'd0, Q - 1);
    sendOp(64'd1, Q - 1);
    sendOp(Q - 1, 64'd1);
    sendOp(Q - 1, Q - 1);
    sendOp(Q - 1, 64'd2);
    sendOp(64'd1, 64'd1);
    drain("R7");
  endtask

  task automatic testBurst();
    curReq = "R4";
    for (int i = 0; i < 300; i++) sendOp(randRes(), randRes());
    drain("R4");
  endtask

  task automatic testLarge();
    curReq = "R6";
    for (int i = 0; i < 100; i++)
      sendOp(Q - 64'(1 + ($urandom & 32'hFFFFF)), Q - 64'(1 + ($urandom & 32'hFFFFF)));
    drain("R6");
  endtask

  task automatic testBubbles();
    curReq = "R5";
    for (int i = 0; i < 200; i++) begin
      if ((i % 3 == 1) || (i % 7 == 0)) idleCycle();
      else sendOp(randRes(), randRes());
    end
    drain("R5");
  endtask

  task automatic testRandom();
    curReq = "R2";
    for (int i = 0; i < 200; i++) begin
      sendOp(randRes(), randRes());
      if (i % 11 == 5) idleCycle();
    end
    drain("R2");
  endtask

  initial begin
    testReset();
    testSingle();
    testCorners();
    testBurst();
    testLarge();
    testBubbles();
    testRandom();
    summary();
    $finish;
  end
endmodule